// File: doc/BRIEF.md
# Register-Port-Limited In-Order Pipeline Controller

This block sequences abstract instruction tokens through four single-slot stages: fetch, decode, issue and execute. A token carries a tag, a mask of source registers and a mask of destination registers over a register space of `NREG` entries. Bit i of a mask stands for register i. The block handles no data and decodes nothing. It only models how many register-file ports each stage may use per cycle, and it holds the pipeline while a token's accesses are still being spread over several cycles.

The decode stage may read at most `RD_PORTS` registers per cycle (default 3). The execute stage may write at most `WR_PORTS` registers per cycle (default 1). Each cycle, the pending mask of the token in that stage loses the registers granted to it. Grants always go to the lowest-numbered pending registers first. The stall is computed at each clock edge from the masks the stages will hold after that edge, so it comes straight from a register.

A small state machine holds the reason for the stall:
- `PS_FLOW`: no stall.
- `PS_RD_HOLD`: decode has more reads pending than the read ports allow.
- `PS_WR_HOLD`: execute has more writes pending than the write ports allow.
- `PS_BOTH_HOLD`: both conditions hold.

At every edge the machine moves to the state given by the pair (decode over its limit, execute over its limit), so any state can reach any other state in one step. When the stall is low, all stages advance together, a new token may enter fetch, and the token leaving execute is retired.

Top module: `ppc_top`

## Requirements
- R1: After reset all four stage valid outputs are 0, `stall` is 0, `in_ready` is 1, `retire` is 0, and both grant masks are 0.
- R2: Each cycle, `rd_grant` marks at most 3 registers, and they are the lowest-numbered registers still pending for the token in decode. Bit i is register i. The grant is 0 when decode is empty.
- R3: `stall` is 1 in every decode cycle in which the token has more than 3 reads still pending. A token with k reads stays in decode for ceil(k/3) cycles, and a token with exactly 3 reads causes no stall.
- R4: Each cycle, `wr_grant` marks at most one register, and it is the lowest-numbered register still pending for the token in execute. The grant is 0 when execute is empty.
- R5: `stall` is 1 in every execute cycle in which the token has more than one write still pending. A token with k ≥ 1 writes stays in execute for k cycles.
- R6: While `stall` is 1, `in_ready` is 0 and no stage valid output changes at the next edge.
- R7: When `stall` is 0, all stages advance together. `retire` is 1 for exactly the cycle in which a token leaves execute, and `retire_tag` carries that token's tag. Tokens retire in the order they were accepted.
- R8: A token with empty read and write masks never causes a stall. Back-to-back empty tokens retire in consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | A token is offered on the in_* inputs |
| in_ready | output | 1 | The offered token is taken at the next edge |
| in_rd | input | NREG | Source register mask of the offered token |
| in_wr | input | NREG | Destination register mask of the offered token |
| in_tag | input | TAGW | Tag of the offered token |
| stall | output | 1 | Pipeline hold; no stage advances at the next edge |
| fetch_vld | output | 1 | Fetch slot occupied |
| dec_vld | output | 1 | Decode slot occupied |
| iss_vld | output | 1 | Issue slot occupied |
| exe_vld | output | 1 | Execute slot occupied |
| rd_grant | output | NREG | Registers read by decode this cycle |
| wr_grant | output | NREG | Registers written by execute this cycle |
| retire | output | 1 | A token leaves execute this cycle |
| retire_tag | output | TAGW | Tag of the retiring token |

## Verification
Single tokens with 5, 4 and exactly 3 scattered reads are sent through an otherwise empty pipeline. Their read-grant sequences separate lowest-first picking from other orders and show when the 3-port limit stalls decode. A lone three-write token does the same for the single write port. A run of empty tokens shows that nothing stalls without port pressure and that retirement takes one cycle per token. A back-to-back mixed stream of heavy and light tokens checks retire order, the hold of all stages during a stall, and that `in_ready` is low while stalled.

// File: rtl/ppc_pkg.sv
package ppc_pkg;

    // Reason the pipeline is held, as registered by the control machine
    typedef enum logic [1:0] {
        PS_FLOW      = 2'd0,
        PS_RD_HOLD   = 2'd1,
        PS_WR_HOLD   = 2'd2,
        PS_BOTH_HOLD = 2'd3
    } pstate_e;

    localparam int unsigned PPC_STAGES = 4;

endpackage

// File: rtl/ppc_pick.sv
// Grants the lowest-numbered LIMIT set bits of req and flags whether
// more bits remain than the limit allows.
module ppc_pick #(
    parameter int unsigned W     = 32,
    parameter int unsigned LIMIT = 3
) (
    input  logic [W-1:0] req,
    output logic [W-1:0] grant,
    output logic         over
);
    localparam int unsigned CW = $clog2(W + 1);

    logic [CW-1:0] cnt;

    always_comb begin
        cnt   = '0;
        grant = '0;
        for (int i = 0; i < int'(W); i++) begin
            if (req[i]) begin
                if (cnt < CW'(LIMIT)) begin
                    grant[i] = 1'b1;
                end
                cnt = cnt + CW'(1);
            end
        end
        over = (cnt > CW'(LIMIT));
    end
endmodule

// File: rtl/ppc_fsm.sv
// Registered hold-reason machine: state register and output decode.
module ppc_fsm
    import ppc_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic rd_over_nxt,
    input  logic wr_over_nxt,
    output logic stall,
    output logic in_ready
);
    pstate_e state_q, state_d;

    always_comb begin
        unique case ({rd_over_nxt, wr_over_nxt})
            2'b00:   state_d = PS_FLOW;
            2'b10:   state_d = PS_RD_HOLD;
            2'b01:   state_d = PS_WR_HOLD;
            default: state_d = PS_BOTH_HOLD;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= PS_FLOW;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        unique case (state_q)
            PS_FLOW: begin
                stall    = 1'b0;
                in_ready = 1'b1;
            end
            PS_RD_HOLD, PS_WR_HOLD, PS_BOTH_HOLD: begin
                stall    = 1'b1;
                in_ready = 1'b0;
            end
            default: begin
                stall    = 1'b1;
                in_ready = 1'b0;
            end
        endcase
    end
endmodule

// File: rtl/ppc_top.sv
module ppc_top
    import ppc_pkg::*;
#(
    parameter int unsigned NREG     = 32,
    parameter int unsigned TAGW     = 8,
    parameter int unsigned RD_PORTS = 3,
    parameter int unsigned WR_PORTS = 1
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            in_valid,
    output logic            in_ready,
    input  logic [NREG-1:0] in_rd,
    input  logic [NREG-1:0] in_wr,
    input  logic [TAGW-1:0] in_tag,
    output logic            stall,
    output logic            fetch_vld,
    output logic            dec_vld,
    output logic            iss_vld,
    output logic            exe_vld,
    output logic [NREG-1:0] rd_grant,
    output logic [NREG-1:0] wr_grant,
    output logic            retire,
    output logic [TAGW-1:0] retire_tag
);
    localparam int unsigned NST   = PPC_STAGES;
    localparam int unsigned S_EXE = NST - 1;
    localparam int unsigned S_ISS = NST - 2;

    // per-stage occupancy, tag and destination mask (destination mask
    // is carried up to issue; execute keeps its own shrinking copy)
    logic            vld_q [NST];
    logic [TAGW-1:0] tag_q [NST];
    logic [NREG-1:0] wr_q  [NST-1];

    logic [NREG-1:0] rd_fetch_q;   // source mask waiting in fetch
    logic [NREG-1:0] rd_pend_q;    // reads still owed by decode
    logic [NREG-1:0] wr_pend_q;    // writes still owed by execute
    logic [NREG-1:0] rd_grant_q, wr_grant_q;

    logic            adv;
    logic [NREG-1:0] rd_pend_d, wr_pend_d;
    logic [NREG-1:0] rd_grant_d, wr_grant_d;
    logic            rd_over_d, wr_over_d;

    assign adv = ~stall;

    // masks each slot will hold after this edge
    assign rd_pend_d = adv ? rd_fetch_q : (rd_pend_q & ~rd_grant_q);
    assign wr_pend_d = adv ? wr_q[S_ISS] : (wr_pend_q & ~wr_grant_q);

    ppc_pick #(.W(NREG), .LIMIT(RD_PORTS)) u_rd_pick (
        .req   (rd_pend_d),
        .grant (rd_grant_d),
        .over  (rd_over_d)
    );

    ppc_pick #(.W(NREG), .LIMIT(WR_PORTS)) u_wr_pick (
        .req   (wr_pend_d),
        .grant (wr_grant_d),
        .over  (wr_over_d)
    );

    ppc_fsm u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .rd_over_nxt (rd_over_d),
        .wr_over_nxt (wr_over_d),
        .stall       (stall),
        .in_ready    (in_ready)
    );

    // fetch slot loads from the input side
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vld_q[0]   <= 1'b0;
            tag_q[0]   <= '0;
            wr_q[0]    <= '0;
            rd_fetch_q <= '0;
        end else if (adv) begin
            vld_q[0]   <= in_valid;
            tag_q[0]   <= in_valid ? in_tag : '0;
            wr_q[0]    <= in_valid ? in_wr : '0;
            rd_fetch_q <= in_valid ? in_rd : '0;
        end
    end

    // later slots shift together on advance
    for (genvar s = 1; s < int'(NST); s++) begin : g_stage
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                vld_q[s] <= 1'b0;
                tag_q[s] <= '0;
            end else if (adv) begin
                vld_q[s] <= vld_q[s-1];
                tag_q[s] <= tag_q[s-1];
            end
        end
        if (s < int'(NST) - 1) begin : g_wr
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    wr_q[s] <= '0;
                end else if (adv) begin
                    wr_q[s] <= wr_q[s-1];
                end
            end
        end
    end

    // pending masks and registered grants
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_pend_q  <= '0;
            wr_pend_q  <= '0;
            rd_grant_q <= '0;
            wr_grant_q <= '0;
        end else begin
            rd_pend_q  <= rd_pend_d;
            wr_pend_q  <= wr_pend_d;
            rd_grant_q <= rd_grant_d;
            wr_grant_q <= wr_grant_d;
        end
    end

    assign fetch_vld  = vld_q[0];
    assign dec_vld    = vld_q[1];
    assign iss_vld    = vld_q[S_ISS];
    assign exe_vld    = vld_q[S_EXE];
    assign rd_grant   = rd_grant_q;
    assign wr_grant   = wr_grant_q;
    assign retire     = adv & vld_q[S_EXE];
    assign retire_tag = tag_q[S_EXE];
endmodule

// File: rtl/ppc_check.sv
module ppc_check #(
    parameter int unsigned NREG     = 32,
    parameter int unsigned RD_PORTS = 3,
    parameter int unsigned WR_PORTS = 1
) (
    input logic            clk,
    input logic            rst_n,
    input logic            in_ready,
    input logic            stall,
    input logic            fetch_vld,
    input logic            dec_vld,
    input logic            iss_vld,
    input logic            exe_vld,
    input logic [NREG-1:0] rd_grant,
    input logic [NREG-1:0] wr_grant,
    input logic            retire
);
    assert_rd_limit_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(rd_grant) <= RD_PORTS);

    assert_rd_owner_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_grant != '0) |-> dec_vld);

    assert_wr_limit_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(wr_grant) <= WR_PORTS);

    assert_wr_owner_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_grant != '0) |-> exe_vld);

    assert_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        stall |=> $stable({fetch_vld, dec_vld, iss_vld, exe_vld}));

    assert_ready_R6: assert property (@(posedge clk) disable iff (!rst_n)
        stall |-> !in_ready);

    assert_retire_R7: assert property (@(posedge clk) disable iff (!rst_n)
        retire |-> (exe_vld && !stall));
endmodule

bind ppc_top ppc_check #(
    .NREG     (NREG),
    .RD_PORTS (RD_PORTS),
    .WR_PORTS (WR_PORTS)
) u_ppc_check (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_ready  (in_ready),
    .stall     (stall),
    .fetch_vld (fetch_vld),
    .dec_vld   (dec_vld),
    .iss_vld   (iss_vld),
    .exe_vld   (exe_vld),
    .rd_grant  (rd_grant),
    .wr_grant  (wr_grant),
    .retire    (retire)
);

// File: tb/tb_ppc_top.sv
`timescale 1ns/1ps
module tb_ppc_top;
    localparam int NREG = 32;
    localparam int TAGW = 8;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            in_valid = 1'b0;
    logic            in_ready;
    logic [NREG-1:0] in_rd = '0;
    logic [NREG-1:0] in_wr = '0;
    logic [TAGW-1:0] in_tag = '0;
    logic            stall, fetch_vld, dec_vld, iss_vld, exe_vld;
    logic [NREG-1:0] rd_grant, wr_grant;
    logic            retire;
    logic [TAGW-1:0] retire_tag;

    ppc_top #(.NREG(NREG), .TAGW(TAGW)) dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
        .in_rd(in_rd), .in_wr(in_wr), .in_tag(in_tag), .stall(stall),
        .fetch_vld(fetch_vld), .dec_vld(dec_vld), .iss_vld(iss_vld),
        .exe_vld(exe_vld), .rd_grant(rd_grant), .wr_grant(wr_grant),
        .retire(retire), .retire_tag(retire_tag)
    );

    always #5 clk = ~clk;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;
    bit mon_on = 1'b0;
    int cyc = 0;

    logic [TAGW-1:0] exp_q [$];
    logic [NREG:0]   rd_log [$];   // {stall, grant}
    logic [NREG:0]   wr_log [$];
    int              ret_cyc [$];
    bit              stall_seen = 1'b0;
    bit              prev_stall = 1'b0;
    logic [3:0]      prev_vld = '0;

    task automatic chk(input bit ok, input string req, input logic [63:0] act,
                       input logic [63:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // monitor: scoreboard on retire, per-cycle hold and ready checks
    always @(negedge clk) begin
        if (mon_on && rst_n) begin
            cyc++;
            if (rd_grant != '0) rd_log.push_back({stall, rd_grant});
            if (wr_grant != '0) wr_log.push_back({stall, wr_grant});
            if (stall) stall_seen = 1'b1;
            chk(in_ready == !stall, "R6 ready", 64'(in_ready), 64'(!stall));
            if (prev_stall)
                chk({fetch_vld, dec_vld, iss_vld, exe_vld} == prev_vld, "R6 hold",
                    64'({fetch_vld, dec_vld, iss_vld, exe_vld}), 64'(prev_vld));
            if (retire) begin
                ret_cyc.push_back(cyc);
                if (exp_q.size() == 0) begin
                    chk(1'b0, "R7 unexpected retire", 64'(retire_tag), 64'hFF);
                end else begin
                    logic [TAGW-1:0] e;
                    e = exp_q.pop_front();
                    chk(retire_tag == e, "R7 retire order", 64'(retire_tag), 64'(e));
                end
            end
            prev_stall = stall;
            prev_vld   = {fetch_vld, dec_vld, iss_vld, exe_vld};
        end
    end

    // driver: offers one token and records it as expected on acceptance
    task automatic push(input logic [NREG-1:0] rd, input logic [NREG-1:0] wr,
                        input logic [TAGW-1:0] tag);
        @(negedge clk);
        in_valid = 1'b1;
        in_rd    = rd;
        in_wr    = wr;
        in_tag   = tag;
        while (!in_ready) @(negedge clk);
        @(posedge clk);
        exp_q.push_back(tag);
    endtask

    task automatic drain();
        @(negedge clk);
        in_valid = 1'b0;
        in_rd    = '0;
        in_wr    = '0;
        while (fetch_vld || dec_vld || iss_vld || exe_vld || exp_q.size() != 0)
            @(negedge clk);
        @(negedge clk);
    endtask

    task automatic clear_logs();
        rd_log.delete();
        wr_log.delete();
        ret_cyc.delete();
        stall_seen = 1'b0;
    endtask

    task automatic expect_log(input string req, input bit is_rd, input int idx,
                              input logic [NREG-1:0] g, input bit st);
        logic [NREG:0] v;
        int n;
        n = is_rd ? rd_log.size() : wr_log.size();
        if (idx >= n) begin
            chk(1'b0, req, 64'(n), 64'(idx + 1));
        end else begin
            v = is_rd ? rd_log[idx] : wr_log[idx];
            chk(v == {st, g}, req, 64'(v), 64'({st, g}));
        end
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        if (!done) begin
            bad++;
            total++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin : main
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk({fetch_vld, dec_vld, iss_vld, exe_vld} == 4'b0, "R1 valids",
            64'({fetch_vld, dec_vld, iss_vld, exe_vld}), 64'(0));
        chk(stall == 1'b0, "R1 stall", 64'(stall), 64'(0));
        chk(in_ready == 1'b1, "R1 ready", 64'(in_ready), 64'(1));
        chk(retire == 1'b0, "R1 retire", 64'(retire), 64'(0));
        chk(rd_grant == '0 && wr_grant == '0, "R1 grants",
            64'({rd_grant, wr_grant}), 64'(0));
        mon_on = 1'b1;

        // R2/R3: five reads on registers 2,5,7,9,30
        clear_logs();
        push(32'h4000_02A4, '0, 8'd1);
        drain();
        chk(rd_log.size() == 2, "R3 five-read cycles", 64'(rd_log.size()), 64'(2));
        expect_log("R2 R3 first read group", 1'b1, 0, 32'h0000_00A4, 1'b1);
        expect_log("R2 R3 second read group", 1'b1, 1, 32'h4000_0200, 1'b0);

        // R3 boundary: exactly three reads on registers 0,4,31
        clear_logs();
        push(32'h8000_0011, '0, 8'd2);
        drain();
        chk(rd_log.size() == 1, "R3 three-read cycles", 64'(rd_log.size()), 64'(1));
        expect_log("R3 three reads no stall", 1'b1, 0, 32'h8000_0011, 1'b0);
        chk(stall_seen == 1'b0, "R3 three reads stall", 64'(stall_seen), 64'(0));

        // R2/R3: four reads on registers 4..7
        clear_logs();
        push(32'h0000_00F0, '0, 8'd3);
        drain();
        expect_log("R2 four reads first", 1'b1, 0, 32'h0000_0070, 1'b1);
        expect_log("R2 four reads second", 1'b1, 1, 32'h0000_0080, 1'b0);

        // R4/R5: three writes on registers 1,4,6
        clear_logs();
        push('0, 32'h0000_0052, 8'd4);
        drain();
        chk(wr_log.size() == 3, "R5 write cycles", 64'(wr_log.size()), 64'(3));
        expect_log("R4 R5 write 1", 1'b0, 0, 32'h0000_0002, 1'b1);
        expect_log("R4 R5 write 4", 1'b0, 1, 32'h0000_0010, 1'b1);
        expect_log("R4 R5 write 6", 1'b0, 2, 32'h0000_0040, 1'b0);

        // R8: back-to-back empty tokens
        clear_logs();
        for (int k = 0; k < 4; k++) push('0, '0, 8'(10 + k));
        drain();
        chk(stall_seen == 1'b0, "R8 empty no stall", 64'(stall_seen), 64'(0));
        chk(ret_cyc.size() == 4, "R8 empty retire count", 64'(ret_cyc.size()), 64'(4));
        if (ret_cyc.size() == 4)
            chk(ret_cyc[3] - ret_cyc[0] == 3, "R8 consecutive retire",
                64'(ret_cyc[3] - ret_cyc[0]), 64'(3));

        // R6/R7: mixed back-to-back stream, order kept through stalls
        clear_logs();
        push(32'h0000_FFFF, 32'h0000_0003, 8'd20);
        push('0, '0, 8'd21);
        push(32'h0000_0001, 32'h0000_00F0, 8'd22);
        push(32'h0000_0007, 32'h0000_0001, 8'd23);
        push('0, 32'h8000_0000, 8'd24);
        push(32'hFFFF_FFFF, '0, 8'd25);
        drain();
        chk(ret_cyc.size() == 6, "R7 mixed retire count", 64'(ret_cyc.size()), 64'(6));
        chk(stall_seen == 1'b1, "R6 mixed stream stalled", 64'(stall_seen), 64'(1));
        chk(rd_log.size() == 6 + 1 + 1 + 11, "R2 mixed read cycles",
            64'(rd_log.size()), 64'(19));

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule